// File: doc/BRIEF.md
# Packed Character Output Sequencer

This block runs one character output command for a punch or typewriter port. In word mode it sends one to eight 5-bit characters taken from the top of a 40-bit sign-magnitude accumulator. In single mode it sends one character taken from a field of the instruction. At the start of a command it loads the accumulator and reads the address field. Word mode applies when the word address lies in the loop range. The low octal digit of the address, not counting the spare bit, gives the character count.

In word mode each character passes through a 5-bit holding register. On every step the top five accumulator bits move into the holding register. The old holding contents go into the low five accumulator bits, and the other 35 bits shift left by five. On the last step of a command the old holding contents are dropped instead of recirculated.

The block steps only when the device signals ready, and it samples an echo-check error on that same ready. After the final character it pulses done, reports overflow if any echo error was seen, and then either requests a branch or halts. The choice depends on whether the next instruction is a transfer-on-overflow.

Top module: `packed_char_out`

## Requirements
- R1: Word mode is selected when the word address cmdAddr[12:1] is at least octal 7760 and the spare bit cmdAddr[0] is 0. The count is the digit cmdAddr[3:1]: the value 0 means eight characters, and the values 1 to 7 mean that many.
- R2: Each character is shown on devChar together with a one-cycle devValid. The next character is shown only after devReady has been sampled high in the cycle after that valid.
- R3: In word mode each character is accOut[39:35]. Its step puts that value into holdOut, puts the old holdOut into accOut[4:0], and shifts accOut[34:0] up by five. The accumulator and holding register change only on a step (devReady) or, for the accumulator, on an accepted command.
- R4: On the final step of a word-mode command, accOut[4:0] becomes zero and the old holding contents are dropped.
- R5: When the word address is below the loop range, exactly one character equal to cmdChar is sent, and accOut and holdOut keep their values.
- R6: A word-mode address whose spare bit is 1 gives a one-cycle illegalAddr pulse in the cycle after cmdValid. It produces no devValid, leaves alphaMode low and changes no state.
- R7: An echo error sampled with devReady sets errLamp. The remaining characters are still sent, and ovflPulse is high in the done cycle.
- R8: If an error occurred and nextIsTov is high in the done cycle, branchReq pulses in that cycle, errLamp clears after it, and haltOut stays low.
- R9: If an error occurred and nextIsTov is low in the done cycle, haltOut rises and errLamp stays set. Both clear when the next command is accepted.
- R10: alphaMode is high from the cycle after a command is accepted through the done cycle, and low otherwise.
- R11: donePulse is a one-cycle pulse in the cycle after the final devReady. A cmdValid that arrives while a command is running is ignored.
- R12: After reset, accOut, holdOut, devValid, donePulse, alphaMode, errLamp and haltOut are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | Start strobe for an output command |
| cmdAddr | input | 13 | Address field: word address in [12:1], spare bit in [0] |
| cmdChar | input | 5 | Character field for single mode |
| accIn | input | 40 | Accumulator value loaded at command start |
| nextIsTov | input | 1 | The next instruction is transfer-on-overflow |
| devReady | input | 1 | Device has taken the current character |
| devEchoErr | input | 1 | Echo-check discrepancy, sampled with devReady |
| devChar | output | 5 | Character presented to the device |
| devValid | output | 1 | One-cycle strobe marking devChar |
| donePulse | output | 1 | Command completed |
| ovflPulse | output | 1 | Overflow report in the done cycle after an error |
| branchReq | output | 1 | Branch request to the transfer-on-overflow target |
| haltOut | output | 1 | Halt after an unhandled error |
| errLamp | output | 1 | Output error indicator |
| alphaMode | output | 1 | Alphanumeric command in progress |
| illegalAddr | output | 1 | Word-mode address with nonzero spare bit |
| accOut | output | 40 | Accumulator contents |
| holdOut | output | 5 | Holding register contents |

## Verification
Some rules can be checked on every cycle, and the checker does that. It confirms that valid and done last one cycle and that overflow appears only together with done. It confirms that a branch leaves no halt and no lit lamp, and that an illegal address never starts the port. It also confirms that the accumulator and holding register stay still unless a ready or an accepted command occurs. Other behaviour needs a reference model that follows whole commands, so only the bench scenarios can show it. This covers the count decode including zero-as-eight, the exact recirculated and zero-filled accumulator words, single-mode characters, error handling through a full word, and halt clearing on the next command.

// File: rtl/pco_pkg.sv
package pco_pkg;
  localparam int ACC_W   = 40;
  localparam int CHAR_W  = 5;
  localparam int ADDR_W  = 13;
  localparam int DIGIT_W = 3;

  typedef struct packed {
    logic load;
    logic step;
    logic last;
    logic multiSel;
  } dpCtrl_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SEND   = 2'd1,
    ST_WAIT   = 2'd2,
    ST_FINISH = 2'd3
  } seqState_t;
endpackage

// File: rtl/pco_datapath.sv
module pco_datapath
  import pco_pkg::*;
#(
  parameter int ACC_W_P  = ACC_W,
  parameter int CHAR_W_P = CHAR_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpCtrl_t             ctrl,
  input  logic [ACC_W_P-1:0]  accIn,
  input  logic [CHAR_W_P-1:0] charIn,
  output logic [ACC_W_P-1:0]  accOut,
  output logic [CHAR_W_P-1:0] holdOut,
  output logic [CHAR_W_P-1:0] charOut
);
  localparam int REST_W = ACC_W_P - CHAR_W_P;

  logic [ACC_W_P-1:0]  accReg;
  logic [CHAR_W_P-1:0] holdReg;
  logic [CHAR_W_P-1:0] singleReg;
  logic [CHAR_W_P-1:0] topChar;
  logic [CHAR_W_P-1:0] refill;

  assign topChar = accReg[ACC_W_P-1 -: CHAR_W_P];
  assign refill  = ctrl.last ? '0 : holdReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accReg    <= '0;
      holdReg   <= '0;
      singleReg <= '0;
    end else if (ctrl.load) begin
      accReg    <= accIn;
      singleReg <= charIn;
    end else if (ctrl.step) begin
      holdReg <= topChar;
      accReg  <= {accReg[REST_W-1:0], refill};
    end
  end

  assign charOut = ctrl.multiSel ? topChar : singleReg;
  assign accOut  = accReg;
  assign holdOut = holdReg;
endmodule

// File: rtl/pco_control.sv
module pco_control
  import pco_pkg::*;
#(
  parameter int          ADDR_W_P  = ADDR_W,
  parameter int          DIGIT_W_P = DIGIT_W,
  parameter int unsigned LOOP_BASE = 'o7760
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cmdValid,
  input  logic [ADDR_W_P-1:0] cmdAddr,
  input  logic                nextIsTov,
  input  logic                devReady,
  input  logic                devEchoErr,
  output dpCtrl_t             ctrl,
  output logic                devValid,
  output logic                donePulse,
  output logic                ovflPulse,
  output logic                branchReq,
  output logic                haltOut,
  output logic                errLamp,
  output logic                alphaMode,
  output logic                illegalAddr
);
  localparam int CNT_W     = DIGIT_W_P + 1;
  localparam int MAX_CHARS = 1 << DIGIT_W_P;
  localparam int WADDR_W   = ADDR_W_P - 1;

  seqState_t              state;
  logic [CNT_W-1:0]       remain;
  logic [CNT_W-1:0]       startCount;
  logic [WADDR_W-1:0]     wordAddr;
  logic [DIGIT_W_P-1:0]   digit;
  logic                   isMulti;
  logic                   multiReg;
  logic                   errSticky;
  logic                   accept;
  logic                   badSpare;

  assign wordAddr = cmdAddr[ADDR_W_P-1:1];
  assign digit    = cmdAddr[DIGIT_W_P:1];
  assign isMulti  = wordAddr >= WADDR_W'(LOOP_BASE);
  assign badSpare = isMulti && cmdAddr[0];
  assign accept   = (state == ST_IDLE) && cmdValid && !badSpare;

  always_comb begin
    if (!isMulti)
      startCount = CNT_W'(1);
    else if (digit == '0)
      startCount = CNT_W'(MAX_CHARS);
    else
      startCount = {1'b0, digit};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      remain      <= '0;
      multiReg    <= 1'b0;
      errSticky   <= 1'b0;
      errLamp     <= 1'b0;
      haltOut     <= 1'b0;
      illegalAddr <= 1'b0;
    end else begin
      illegalAddr <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (cmdValid && badSpare) begin
            illegalAddr <= 1'b1;
          end else if (accept) begin
            remain    <= startCount;
            multiReg  <= isMulti;
            errSticky <= 1'b0;
            errLamp   <= 1'b0;
            haltOut   <= 1'b0;
            state     <= ST_SEND;
          end
        end
        ST_SEND: state <= ST_WAIT;
        ST_WAIT: begin
          if (devReady) begin
            if (devEchoErr) begin
              errSticky <= 1'b1;
              errLamp   <= 1'b1;
            end
            remain <= remain - CNT_W'(1);
            state  <= (remain == CNT_W'(1)) ? ST_FINISH : ST_SEND;
          end
        end
        ST_FINISH: begin
          if (errSticky) begin
            if (nextIsTov) errLamp <= 1'b0;
            else           haltOut <= 1'b1;
          end
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctrl.load     = accept;
    ctrl.step     = (state == ST_WAIT) && devReady && multiReg;
    ctrl.last     = remain == CNT_W'(1);
    ctrl.multiSel = multiReg;
  end

  assign devValid  = state == ST_SEND;
  assign donePulse = state == ST_FINISH;
  assign ovflPulse = donePulse && errSticky;
  assign branchReq = ovflPulse && nextIsTov;
  assign alphaMode = state != ST_IDLE;
endmodule

// File: rtl/packed_char_out.sv
module packed_char_out
  import pco_pkg::*;
#(
  parameter int          ACC_W_P   = ACC_W,
  parameter int          CHAR_W_P  = CHAR_W,
  parameter int          ADDR_W_P  = ADDR_W,
  parameter int          DIGIT_W_P = DIGIT_W,
  parameter int unsigned LOOP_BASE = 'o7760
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cmdValid,
  input  logic [ADDR_W_P-1:0] cmdAddr,
  input  logic [CHAR_W_P-1:0] cmdChar,
  input  logic [ACC_W_P-1:0]  accIn,
  input  logic                nextIsTov,
  input  logic                devReady,
  input  logic                devEchoErr,
  output logic [CHAR_W_P-1:0] devChar,
  output logic                devValid,
  output logic                donePulse,
  output logic                ovflPulse,
  output logic                branchReq,
  output logic                haltOut,
  output logic                errLamp,
  output logic                alphaMode,
  output logic                illegalAddr,
  output logic [ACC_W_P-1:0]  accOut,
  output logic [CHAR_W_P-1:0] holdOut
);
  dpCtrl_t ctrl;

  pco_control #(
    .ADDR_W_P(ADDR_W_P), .DIGIT_W_P(DIGIT_W_P), .LOOP_BASE(LOOP_BASE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdAddr(cmdAddr),
    .nextIsTov(nextIsTov), .devReady(devReady), .devEchoErr(devEchoErr),
    .ctrl(ctrl), .devValid(devValid), .donePulse(donePulse),
    .ovflPulse(ovflPulse), .branchReq(branchReq), .haltOut(haltOut),
    .errLamp(errLamp), .alphaMode(alphaMode), .illegalAddr(illegalAddr)
  );

  pco_datapath #(
    .ACC_W_P(ACC_W_P), .CHAR_W_P(CHAR_W_P)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .accIn(accIn), .charIn(cmdChar),
    .accOut(accOut), .holdOut(holdOut), .charOut(devChar)
  );
endmodule

// File: rtl/pco_checker.sv
module pco_checker #(
  parameter int ACC_W_P  = 40,
  parameter int CHAR_W_P = 5
) (
  input logic                clk,
  input logic                rstN,
  input logic                cmdValid,
  input logic                devReady,
  input logic                devValid,
  input logic                donePulse,
  input logic                ovflPulse,
  input logic                branchReq,
  input logic                haltOut,
  input logic                errLamp,
  input logic                alphaMode,
  input logic                illegalAddr,
  input logic [ACC_W_P-1:0]  accOut,
  input logic [CHAR_W_P-1:0] holdOut
);
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    devValid |=> !devValid); // R2
  AST_HOLD_STILL: assert property (@(posedge clk) disable iff (!rstN)
    !devReady |=> $stable(holdOut)); // R3
  AST_ACC_STILL: assert property (@(posedge clk) disable iff (!rstN)
    (!devReady && !cmdValid) |=> $stable(accOut)); // R3
  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    illegalAddr |-> (!alphaMode && !devValid)); // R6
  AST_OVFL_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    ovflPulse |-> donePulse); // R7
  AST_BRANCH_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    branchReq |=> (!haltOut && !errLamp)); // R8
  AST_ALPHA_ON_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (devValid || donePulse) |-> alphaMode); // R10
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse); // R11
endmodule

bind packed_char_out pco_checker #(.ACC_W_P(ACC_W_P), .CHAR_W_P(CHAR_W_P)) u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .devReady(devReady),
  .devValid(devValid), .donePulse(donePulse), .ovflPulse(ovflPulse),
  .branchReq(branchReq), .haltOut(haltOut), .errLamp(errLamp),
  .alphaMode(alphaMode), .illegalAddr(illegalAddr), .accOut(accOut),
  .holdOut(holdOut)
);

// File: tb/packed_char_out_bench.sv
`timescale 1ns/1ps
module packed_char_out_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [12:0] cmdAddr = '0;
  logic [4:0]  cmdChar = '0;
  logic [39:0] accIn = '0;
  logic        nextIsTov = 1'b0;
  logic        devReady = 1'b0;
  logic        devEchoErr = 1'b0;
  logic [4:0]  devChar;
  logic        devValid, donePulse, ovflPulse, branchReq, haltOut;
  logic        errLamp, alphaMode, illegalAddr;
  logic [39:0] accOut;
  logic [4:0]  holdOut;

  int checks = 0;
  int fails = 0;
  bit expBusy = 1'b0;
  logic [39:0] mAcc = '0;
  logic [4:0]  mHold = '0;
  int cycles = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  packed_char_out u_packed_char_out (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdAddr(cmdAddr),
    .cmdChar(cmdChar), .accIn(accIn), .nextIsTov(nextIsTov),
    .devReady(devReady), .devEchoErr(devEchoErr), .devChar(devChar),
    .devValid(devValid), .donePulse(donePulse), .ovflPulse(ovflPulse),
    .branchReq(branchReq), .haltOut(haltOut), .errLamp(errLamp),
    .alphaMode(alphaMode), .illegalAddr(illegalAddr), .accOut(accOut),
    .holdOut(holdOut)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R10: busy indicator compared with the model on every clock
  always @(negedge clk) begin
    if (rstN && !finished) check(alphaMode == expBusy, "R10 alphaMode", 64'(alphaMode), 64'(expBusy));
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic runCmd(input logic [12:0] addr, input logic [4:0] ch,
                        input logic [39:0] a, input int delay,
                        input logic [7:0] errMask, input bit tov, input bit poke);
    bit multi;
    int n;
    bit anyErr;
    logic [4:0] expCh [8];
    logic [4:0] top;
    multi = addr[12:1] >= 12'o7760;
    n = !multi ? 1 : (addr[3:1] == 3'd0 ? 8 : int'(addr[3:1]));
    anyErr = 1'b0;
    mAcc = a;
    for (int i = 0; i < n; i++) begin
      if (errMask[i]) anyErr = 1'b1;
      if (multi) begin
        top = mAcc[39:35];
        expCh[i] = top;
        mAcc = {mAcc[34:0], (i == n - 1) ? 5'b0 : mHold};
        mHold = top;
      end else expCh[i] = ch;
    end
    @(negedge clk);
    cmdAddr = addr; cmdChar = ch; accIn = a; cmdValid = 1'b1;
    @(posedge clk); #1;
    cmdValid = 1'b0; expBusy = 1'b1;
    for (int i = 0; i < n; i++) begin
      for (int w = 0; w < 50; w++) begin
        @(negedge clk);
        if (devValid) break;
      end
      if (i == 0) begin
        check(!haltOut && !errLamp, "R9 cleared on accept", {haltOut, errLamp}, 0);
      end
      check(devValid, "R2 valid seen", 64'(devValid), 1);
      check(devChar == expCh[i], multi ? "R3 char" : "R5 char", 64'(devChar), 64'(expCh[i]));
      if (poke && i == 0) begin cmdValid = 1'b1; accIn = ~a; end
      repeat (delay + 1) begin
        @(negedge clk);
        check(!devValid, "R2 hold off until ready", 64'(devValid), 0);
      end
      cmdValid = 1'b0;
      devReady = 1'b1; devEchoErr = errMask[i]; nextIsTov = tov;
      @(posedge clk); #1;
      devReady = 1'b0; devEchoErr = 1'b0;
    end
    @(negedge clk);
    check(donePulse, "R11 done", 64'(donePulse), 1);
    check(ovflPulse == anyErr, "R7 ovfl", 64'(ovflPulse), 64'(anyErr));
    check(errLamp == anyErr, "R7 lamp", 64'(errLamp), 64'(anyErr));
    check(branchReq == (anyErr && tov), "R8 branch", 64'(branchReq), 64'(anyErr && tov));
    check(accOut == mAcc, multi ? "R4 acc" : "R5 acc", accOut, mAcc);
    check(holdOut == mHold, multi ? "R3 hold" : "R5 hold", holdOut, mHold);
    @(posedge clk); #1;
    expBusy = 1'b0; nextIsTov = 1'b0;
    @(negedge clk);
    check(!donePulse, "R11 done one cycle", 64'(donePulse), 0);
    check(haltOut == (anyErr && !tov), "R9 halt", 64'(haltOut), 64'(anyErr && !tov));
    check(errLamp == (anyErr && !tov), "R8 lamp after", 64'(errLamp), 64'(anyErr && !tov));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(accOut == 0 && holdOut == 0, "R12 regs", {accOut, holdOut}, 0);
    check({devValid, donePulse, alphaMode, errLamp, haltOut} == 0, "R12 flags",
          {devValid, donePulse, alphaMode, errLamp, haltOut}, 0);
    rstN = 1'b1;
    // R1: digit 4 gives four characters
    runCmd({12'o7764, 1'b0}, 5'h00, 40'h12_3456_789A, 0, 8'h00, 1'b0, 1'b0);
    // R1: digit 0 gives eight characters
    runCmd({12'o7770, 1'b0}, 5'h00, 40'hF0_E1D2_C3B4, 2, 8'h00, 1'b0, 1'b0);
    // R1: digit 1 gives one character, R4 zero fill
    runCmd({12'o7771, 1'b0}, 5'h00, 40'hAB_CDEF_0123, 1, 8'h00, 1'b0, 1'b0);
    // R5: below loop range
    runCmd({12'o0123, 1'b0}, 5'h15, 40'h55_AA55_AA55, 0, 8'h00, 1'b0, 1'b0);
    // R7 R8: error mid-word with transfer-on-overflow following
    runCmd({12'o7763, 1'b0}, 5'h00, 40'h0F_1E2D_3C4B, 0, 8'h02, 1'b1, 1'b0);
    // R9: error without transfer-on-overflow halts
    runCmd({12'o7762, 1'b0}, 5'h00, 40'h80_0000_0001, 1, 8'h01, 1'b0, 1'b0);
    // R9 R11: next command clears halt; cmdValid while busy is ignored
    runCmd({12'o7775, 1'b0}, 5'h00, 40'h3C_5A69_7887, 0, 8'h00, 1'b0, 1'b1);
    // R7 R8: single-character error
    runCmd({12'o0400, 1'b0}, 5'h0B, 40'h01_0203_0405, 0, 8'h01, 1'b1, 1'b0);
    // R6: spare bit set in loop range
    @(negedge clk);
    cmdAddr = {12'o7764, 1'b1}; accIn = 40'hFF_FFFF_FFFF; cmdValid = 1'b1;
    @(posedge clk); #1; cmdValid = 1'b0;
    @(negedge clk);
    check(illegalAddr, "R6 illegal pulse", 64'(illegalAddr), 1);
    check(!devValid, "R6 no valid", 64'(devValid), 0);
    @(negedge clk);
    check(!illegalAddr, "R6 pulse one cycle", 64'(illegalAddr), 0);
    check(!devValid, "R6 still no valid", 64'(devValid), 0);
    check(accOut == mAcc && holdOut == mHold, "R6 state kept", {accOut, holdOut}, {mAcc, mHold});
    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule